// File: doc/BRIEF.md
# Frame-Locked Raster Timing Generator

This block produces horizontal sync, vertical sync and active-video timing for a video output whose pixel clock is derived from the input video clock. The horizontal counter counts half lines: it reloads after half the full line length, and a phase bit selects the first or second half of the line. A vertical counter steps once per half line, and its upper bits give the line number. The frame period is therefore the programmed line count times the line period.

A frame pulse from the input side arrives without any timing relation to the pixel clock. It passes through a two-stage flip-flop synchroniser, and its rising edge is detected. Each rising edge moves the output raster to its origin, the first pixel of line 0. The output frame rate then follows the input frame rate, and no frame is ever skipped. The horizontal parameters (front porch, sync width, back porch and active width) and the vertical parameters (line count and active line count) are held in a shadow copy. That copy is refreshed only at the end of a frame or at a realignment, so no line is ever built partly from old values and partly from new ones. A full line length that is odd cannot be split into two equal halves. The block raises a sticky error flag when it sees one.

Top module: `frame_lock_timing`

## Requirements
- R1: While reset is high and right after it is released, hpos and vline are 0 and len_err is 0.
- R2: The full line length L is the sum of front porch, sync width, back porch and active width. hpos counts 0 to L-1 and then returns to 0, in two half-line passes of L/2 cycles each.
- R3: vline advances by one each time hpos returns to 0. After line cfg_lines-1 it returns to 0, and hpos is then 0 as well.
- R4: hsync is high exactly when front ≤ hpos < front+sync.
- R5: de is high exactly when hpos ≥ front+sync+back and vline < vactive. It is never high together with hsync.
- R6: vsync is high exactly when vactive+V_FRONT ≤ vline < vactive+V_FRONT+V_SYNC. The defaults are V_FRONT=1 and V_SYNC=1.
- R7: If the live configured full line length is odd, len_err goes high on the next clock edge and stays high until reset. The line period is then truncated to 2·floor(L/2) cycles.
- R8: frame_in passes through a two-flop synchroniser. When it rises before clock edge P0, the position is hpos=0, vline=0 after edge P2. From there counting continues normally.
- R9: Each rising edge of frame_in causes exactly one realignment. Holding frame_in high causes no further realignments.
- R10: Configuration inputs take effect only at the start of a new frame, either after a natural frame wrap or after a realignment. Changes made in the middle of a frame leave the current frame's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Asynchronous frame pulse from the input side |
| cfg_front | input | 12 | Horizontal front porch in pixels |
| cfg_sync | input | 12 | Horizontal sync width in pixels |
| cfg_back | input | 12 | Horizontal back porch in pixels |
| cfg_active | input | 12 | Active pixels per line |
| cfg_lines | input | 11 | Total lines per frame |
| cfg_vactive | input | 11 | Active lines per frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active video |
| hpos | output | 14 | Pixel position within the line |
| vline | output | 11 | Line number within the frame |
| len_err | output | 1 | Sticky odd-line-length flag |

## Verification
The hardest situation to reach is a realignment that arrives in the middle of a frame while a configuration change is still pending. The pulse must land on a cycle that is not a frame wrap, and it must be held high long enough to show that it does not trigger again. The bench lets a configuration change settle across a natural frame wrap first. It then raises frame_in part way through a frame and holds it high for several lines, and it compares every output on every cycle against an arithmetic model of the raster. A later odd-length setting, followed by a return to an even length, shows both the truncated line period and that the error flag stays set.

// File: rtl/tg_pkg.sv
package tg_pkg;

    localparam int TG_HW = 12;
    localparam int TG_VW = 11;

    typedef struct packed {
        logic [TG_HW-1:0] front;
        logic [TG_HW-1:0] sync;
        logic [TG_HW-1:0] back;
        logic [TG_HW-1:0] active;
        logic [TG_VW-1:0] lines;
        logic [TG_VW-1:0] vact;
    } tg_cfg_t;

    typedef enum logic [1:0] {
        H_FRONT  = 2'd0,
        H_SYNC   = 2'd1,
        H_BACK   = 2'd2,
        H_ACTIVE = 2'd3
    } tg_hregion_e;

    // Full line length in pixel cycles
    function automatic logic [TG_HW+1:0] line_len(input tg_cfg_t c);
        return {2'b00, c.front} + {2'b00, c.sync} + {2'b00, c.back} + {2'b00, c.active};
    endfunction

    // Half-line reload length (truncates when the full length is odd)
    function automatic logic [TG_HW:0] half_len(input tg_cfg_t c);
        logic [TG_HW+1:0] full;
        full = line_len(c);
        return full[TG_HW+1:1];
    endfunction

    function automatic logic len_is_odd(input tg_cfg_t c);
        logic [TG_HW+1:0] full;
        full = line_len(c);
        return full[0];
    endfunction

endpackage

// File: rtl/tg_sync_edge.sv
module tg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/tg_cfg_shadow.sv
module tg_cfg_shadow
    import tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  tg_cfg_t live,
    output tg_cfg_t shadow,
    output logic    len_err
);
    always_ff @(posedge clk) begin
        if (rst || load) shadow <= live;
    end

    always_ff @(posedge clk) begin
        if (rst)                   len_err <= 1'b0;
        else if (len_is_odd(live)) len_err <= 1'b1;
    end
endmodule

// File: rtl/tg_counter.sv
module tg_counter
    import tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             realign,
    input  tg_cfg_t          cfg,
    output logic [TG_HW+1:0] hpos,
    output logic [TG_VW-1:0] vline,
    output logic             frame_end
);
    logic [TG_HW:0]   hcnt;
    logic             hsel;
    logic [TG_VW:0]   vhalf;
    logic [TG_HW:0]   half;
    logic             h_term;
    logic             v_term;
    logic [TG_VW:0]   v_last;

    assign half   = half_len(cfg);
    assign h_term = (half == '0) || (hcnt == half - 1'b1);
    assign v_last = {cfg.lines, 1'b0} - 1'b1;
    assign v_term = (vhalf == v_last);

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            hcnt  <= '0;
            hsel  <= 1'b0;
            vhalf <= '0;
        end else if (h_term) begin
            hcnt <= '0;
            hsel <= ~hsel;
            if (v_term) vhalf <= '0;
            else        vhalf <= vhalf + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign frame_end = h_term & v_term;
    assign hpos      = hsel ? ({1'b0, half} + {1'b0, hcnt}) : {1'b0, hcnt};
    assign vline     = vhalf[TG_VW:1];
endmodule

// File: rtl/tg_decode.sv
module tg_decode
    import tg_pkg::*;
#(
    parameter int V_FRONT = 1,
    parameter int V_SYNC  = 1
) (
    input  tg_cfg_t          cfg,
    input  logic [TG_HW+1:0] hpos,
    input  logic [TG_VW-1:0] vline,
    output logic             hsync,
    output logic             vsync,
    output logic             de
);
    localparam logic [TG_VW+1:0] VF_W = (TG_VW+2)'(V_FRONT);
    localparam logic [TG_VW+1:0] VS_W = (TG_VW+2)'(V_SYNC);

    tg_hregion_e      region;
    logic [TG_HW+1:0] e_front, e_sync, e_back;
    logic [TG_VW+1:0] v_lo, v_hi, vl_w;

    always_comb begin
        e_front = {2'b00, cfg.front};
        e_sync  = e_front + {2'b00, cfg.sync};
        e_back  = e_sync + {2'b00, cfg.back};
        if (hpos < e_front)     region = H_FRONT;
        else if (hpos < e_sync) region = H_SYNC;
        else if (hpos < e_back) region = H_BACK;
        else                    region = H_ACTIVE;
    end

    always_comb begin
        vl_w  = {2'b00, vline};
        v_lo  = {2'b00, cfg.vact} + VF_W;
        v_hi  = v_lo + VS_W;
        hsync = (region == H_SYNC);
        de    = (region == H_ACTIVE) && (vline < cfg.vact);
        vsync = (vl_w >= v_lo) && (vl_w < v_hi);
    end
endmodule

// File: rtl/frame_lock_timing.sv
module frame_lock_timing
    import tg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int V_FRONT     = 1,
    parameter int V_SYNC      = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_in,
    input  logic [TG_HW-1:0] cfg_front,
    input  logic [TG_HW-1:0] cfg_sync,
    input  logic [TG_HW-1:0] cfg_back,
    input  logic [TG_HW-1:0] cfg_active,
    input  logic [TG_VW-1:0] cfg_lines,
    input  logic [TG_VW-1:0] cfg_vactive,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [TG_HW+1:0] hpos,
    output logic [TG_VW-1:0] vline,
    output logic             len_err
);
    tg_cfg_t live;
    tg_cfg_t shadow;
    logic    rise_pulse;
    logic    frame_end;

    assign live = '{front: cfg_front, sync: cfg_sync, back: cfg_back,
                    active: cfg_active, lines: cfg_lines, vact: cfg_vactive};

    tg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(frame_in), .rise(rise_pulse)
    );

    tg_cfg_shadow u_shadow (
        .clk(clk), .rst(rst), .load(frame_end | rise_pulse),
        .live(live), .shadow(shadow), .len_err(len_err)
    );

    tg_counter u_count (
        .clk(clk), .rst(rst), .realign(rise_pulse), .cfg(shadow),
        .hpos(hpos), .vline(vline), .frame_end(frame_end)
    );

    tg_decode #(.V_FRONT(V_FRONT), .V_SYNC(V_SYNC)) u_dec (
        .cfg(shadow), .hpos(hpos), .vline(vline),
        .hsync(hsync), .vsync(vsync), .de(de)
    );
endmodule

// File: rtl/tg_checker.sv
module tg_checker
    import tg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rise_pulse,
    input logic             frame_end,
    input logic [TG_HW+1:0] hpos,
    input logic [TG_VW-1:0] vline,
    input logic             hsync,
    input logic             de,
    input logic             len_err,
    input logic [TG_HW-1:0] sh_front
);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

    assert_realign_origin_R8: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> (hpos == '0) && (vline == '0));

    assert_single_realign_R9: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

    assert_de_not_hsync_R5: assert property (@(posedge clk) disable iff (rst)
        de |-> !hsync);

    assert_hsync_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (hpos == {2'b00, sh_front}));

    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !rise_pulse) |=> (hpos == '0) && (vline == '0));
endmodule

bind frame_lock_timing tg_checker u_chk (
    .clk(clk), .rst(rst), .rise_pulse(rise_pulse), .frame_end(frame_end),
    .hpos(hpos), .vline(vline), .hsync(hsync), .de(de),
    .len_err(len_err), .sh_front(shadow.front)
);

// File: tb/frame_lock_timing_tb.sv
module frame_lock_timing_tb;
    import tg_pkg::*;

    localparam int VF = 1;
    localparam int VS = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_in = 1'b0;
    logic [TG_HW-1:0] cfg_front, cfg_sync, cfg_back, cfg_active;
    logic [TG_VW-1:0] cfg_lines, cfg_vactive;
    logic hsync, vsync, de, len_err;
    logic [TG_HW+1:0] hpos;
    logic [TG_VW-1:0] vline;

    frame_lock_timing u_dut (
        .clk(clk), .rst(rst), .frame_in(frame_in),
        .cfg_front(cfg_front), .cfg_sync(cfg_sync), .cfg_back(cfg_back),
        .cfg_active(cfg_active), .cfg_lines(cfg_lines), .cfg_vactive(cfg_vactive),
        .hsync(hsync), .vsync(vsync), .de(de), .hpos(hpos), .vline(vline),
        .len_err(len_err)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit cmp_en = 0;
    bit done = 0;
    string pos_tag = "R2";

    // Arithmetic raster model
    int mx = 0, my = 0, pend = 0;
    int sf, ss, sb, sa, sl, sv;
    bit merr = 0, prev_fin = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", tag, act, exp, mx, my);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mx = 0; my = 0; pend = 0; merr = 0;
            sf = cfg_front; ss = cfg_sync; sb = cfg_back; sa = cfg_active;
            sl = cfg_lines; sv = cfg_vactive;
        end else begin
            int ll;
            if ((cfg_front + cfg_sync + cfg_back + cfg_active) % 2 == 1) merr = 1;
            ll = ((sf + ss + sb + sa) / 2) * 2;
            if (pend == 1) begin
                mx = 0; my = 0;
                sf = cfg_front; ss = cfg_sync; sb = cfg_back; sa = cfg_active;
                sl = cfg_lines; sv = cfg_vactive;
            end else if (mx == ll - 1) begin
                mx = 0;
                if (my == sl - 1) begin
                    my = 0;
                    sf = cfg_front; ss = cfg_sync; sb = cfg_back; sa = cfg_active;
                    sl = cfg_lines; sv = cfg_vactive;
                end else my++;
            end else mx++;
            if (pend > 0) pend--;
            if (frame_in && !prev_fin) pend = 2;
        end
        prev_fin = frame_in;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            bit eh, ed, ev;
            eh = (mx >= sf) && (mx < sf + ss);
            ed = (mx >= sf + ss + sb) && (my < sv);
            ev = (my >= sv + VF) && (my < sv + VF + VS);
            chk(hpos == mx, pos_tag, hpos, mx);
            chk(vline == my, (pos_tag == "R2") ? "R3" : pos_tag, vline, my);
            chk(hsync == eh, "R4", hsync, eh);
            chk(de == ed, "R5", de, ed);
            chk(vsync == ev, "R6", vsync, ev);
            chk(len_err == merr, "R7", len_err, merr);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        // config A: 2+3+1+10 = 16 pixels, 6 lines, 3 active
        cfg_front = 2; cfg_sync = 3; cfg_back = 1; cfg_active = 10;
        cfg_lines = 6; cfg_vactive = 3;
        run(4);
        chk(hpos == 0, "R1", hpos, 0);
        chk(vline == 0, "R1", vline, 0);
        chk(len_err == 0, "R1", len_err, 0);
        rst = 1'b0;
        cmp_en = 1;
        run(230);
        // R10: change mid-frame to config B (1+2+3+6 = 12, 5 lines, 2 active)
        pos_tag = "R10";
        cfg_front = 1; cfg_sync = 2; cfg_back = 3; cfg_active = 6;
        cfg_lines = 5; cfg_vactive = 2;
        run(300);
        // R8 / R9: mid-frame realignment, pulse held high
        run(17);
        pos_tag = "R8";
        frame_in = 1'b1;
        run(6);
        pos_tag = "R9";
        run(60);
        frame_in = 1'b0;
        run(40);
        pos_tag = "R8";
        frame_in = 1'b1;
        run(3);
        frame_in = 1'b0;
        run(100);
        // R7: odd length 1+2+3+7 = 13 -> 12-cycle lines
        pos_tag = "R7";
        cfg_active = 7;
        run(2);
        chk(len_err == 1, "R7", len_err, 1);
        run(200);
        cfg_active = 6;
        run(30);
        chk(len_err == 1, "R7", len_err, 1);
        run(150);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule